// File: doc/BRIEF.md
# Nibble ALU with Skip Decision

This block is the execution stage of a small 4-bit controller. Each cycle it can accept one 16-bit instruction word together with the values already fetched for it: the register operand, the memory operand and the current carry/borrow flag. It returns the computed nibble, the carry or borrow that the operation produced, a write-back target and a set of write enables. It also returns a skip decision, which tells the sequencer to discard the next instruction. Arithmetic, compare and bit-test instructions drive this decision, so no conditional branch is needed.

The instruction word has four fields. The opcode sits in bits 15:10, the memory row in bits 9:8 and the memory column in bits 7:4. Bits 3:0 hold a register number, an immediate value or a bit mask, depending on the opcode. Register operands are locations 0h to Fh of bank 0. Memory operands are addressed by row and column. The register file, the data memory, the program counter and the stack lie outside the block. All outputs are registered and appear one clock edge after the instruction is presented.

Top module: `nibble_alu_skip`

## Requirements
- R1: `wb_addr_o` is `{2'b00, instr[3:0]}` for instructions whose destination is a register. For every other instruction it is `{instr[9:8], instr[7:4]}`.
- R2: Add opcodes 010000 to 010111 work as follows. Bit 2 = 0 computes R+M into the register. Bit 2 = 1 computes M+I into memory. Bit 1 = 1 also adds the carry input. `c_o` is the carry out of the 4-bit sum and `res_o` is the low 4 bits.
- R3: Subtract opcodes 011000 to 011111 follow the same bit meanings with subtraction: R−M or M−I, minus the borrow input when bit 1 = 1. `c_o` = 1 means a borrow occurred.
- R4: When opcode bit 0 = 1 in the add or subtract groups, `skip_o` equals the carry or borrow produced. When bit 0 = 0, `skip_o` is 0.
- R5: `c_we_o` is 1 only for the add and subtract forms with opcode bit 1 = 1. Every other instruction, compares included, leaves it at 0.
- R6: Register compares: 000100 skips when R = M, and 000101 skips when R ≥ M (unsigned, no borrow).
- R7: Immediate compares: 000110 skips when M = I, 000001 when M ≠ I, 000111 when M ≥ I, and 000011 when M < I.
- R8: Logic opcodes are 001000 R&M, 001010 R|M and 001100 R^M, each into the register. Their immediate forms are 001001 M&I, 001011 M|I and 001110 M^I, each into memory. Logic opcodes never write the carry, and `c_o` is 0.
- R9: Opcode 111100 skips when every bit of M selected by mask instr[3:0] is 1. Opcode 111101 skips when every selected bit is 0. An empty mask skips for both.
- R10: Compares, bit tests, other opcodes and cycles with `valid_i` = 0 assert no write enable, give `res_o` = 0 and `c_o` = 0, and never skip unless R6, R7 or R9 says so.
- R11: Outputs change one rising edge after `valid_i` is sampled. While `rst_n` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 16 | Instruction word |
| r_i | input | 4 | Register operand value |
| m_i | input | 4 | Memory operand value |
| c_i | input | 1 | Current carry/borrow flag |
| res_o | output | 4 | Result nibble |
| c_o | output | 1 | Carry or borrow produced |
| c_we_o | output | 1 | Update carry flag with `c_o` |
| r_we_o | output | 1 | Write result to register |
| m_we_o | output | 1 | Write result to memory |
| skip_o | output | 1 | Skip the next instruction |
| wb_addr_o | output | 6 | Write-back address {row, column} |

## Verification
The bench builds the block with its default widths: a 4-bit data path, a 2-bit row and a 4-bit column. With these widths, operands of 0h and Fh and immediates of 0 and 15 reach the exact overflow and underflow boundaries of every add and subtract form. The vectors cover each opcode group with the carry input set and clear, carry and borrow at exactly the nibble boundary, equality and off-by-one for every compare, and an empty bit-test mask. Directed steps check the reset state, the idle cycle that follows a skipping instruction, and an opcode outside every group.

// File: rtl/nibble_alu_skip.sv
module nibble_alu_skip #(
  parameter int DW    = 4,
  parameter int ROW_W = 2,
  parameter int COL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   valid_i,
  input  logic [5+ROW_W+COL_W+DW:0] instr_i,
  input  logic [DW-1:0]          r_i,
  input  logic [DW-1:0]          m_i,
  input  logic                   c_i,
  output logic [DW-1:0]          res_o,
  output logic                   c_o,
  output logic                   c_we_o,
  output logic                   r_we_o,
  output logic                   m_we_o,
  output logic                   skip_o,
  output logic [ROW_W+COL_W-1:0] wb_addr_o
);
  localparam int IW = 6 + ROW_W + COL_W + DW;
  localparam int AW = ROW_W + COL_W;

  logic [5:0]       op;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [DW-1:0]    lo;
  assign op  = instr_i[IW-1 -: 6];
  assign row = instr_i[DW+COL_W +: ROW_W];
  assign col = instr_i[DW +: COL_W];
  assign lo  = instr_i[DW-1:0];

  logic          arith, is_sub, imm_form, use_c, do_skip;
  logic [DW-1:0] a, b;
  logic [DW:0]   sum, dif, cmp_rm, cmp_mi;

  assign arith    = (op[5:4] == 2'b01);
  assign is_sub   = op[3];
  assign imm_form = op[2];
  assign use_c    = op[1];
  assign do_skip  = op[0];
  assign a        = imm_form ? m_i : r_i;
  assign b        = imm_form ? lo  : m_i;
  assign sum      = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, use_c & c_i};
  assign dif      = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, use_c & c_i};
  assign cmp_rm   = {1'b0, r_i} - {1'b0, m_i};
  assign cmp_mi   = {1'b0, m_i} - {1'b0, lo};

  logic [DW-1:0] n_res;
  logic          n_c, n_cwe, n_rwe, n_mwe, n_skip, reg_dest;

  always_comb begin
    n_res = '0; n_c = 1'b0; n_cwe = 1'b0; n_rwe = 1'b0; n_mwe = 1'b0;
    n_skip = 1'b0; reg_dest = 1'b0;
    if (arith) begin
      n_res    = is_sub ? dif[DW-1:0] : sum[DW-1:0];
      n_c      = is_sub ? dif[DW] : sum[DW];
      n_cwe    = use_c;
      n_skip   = do_skip & n_c;
      reg_dest = !imm_form;
      n_rwe    = !imm_form;
      n_mwe    = imm_form;
    end else begin
      case (op)
        6'b000100: n_skip = (cmp_rm[DW-1:0] == '0);
        6'b000101: n_skip = !cmp_rm[DW];
        6'b000110: n_skip = (cmp_mi[DW-1:0] == '0);
        6'b000001: n_skip = (cmp_mi[DW-1:0] != '0);
        6'b000111: n_skip = !cmp_mi[DW];
        6'b000011: n_skip = cmp_mi[DW];
        6'b001000: begin n_res = r_i & m_i; n_rwe = 1'b1; reg_dest = 1'b1; end
        6'b001010: begin n_res = r_i | m_i; n_rwe = 1'b1; reg_dest = 1'b1; end
        6'b001100: begin n_res = r_i ^ m_i; n_rwe = 1'b1; reg_dest = 1'b1; end
        6'b001001: begin n_res = m_i & lo; n_mwe = 1'b1; end
        6'b001011: begin n_res = m_i | lo; n_mwe = 1'b1; end
        6'b001110: begin n_res = m_i ^ lo; n_mwe = 1'b1; end
        6'b111100: n_skip = ((m_i & lo) == lo);
        6'b111101: n_skip = ((m_i & lo) == '0);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_o <= '0; c_o <= 1'b0; c_we_o <= 1'b0; r_we_o <= 1'b0;
      m_we_o <= 1'b0; skip_o <= 1'b0; wb_addr_o <= '0;
    end else begin
      res_o     <= valid_i ? n_res : '0;
      c_o       <= valid_i & n_c;
      c_we_o    <= valid_i & n_cwe;
      r_we_o    <= valid_i & n_rwe;
      m_we_o    <= valid_i & n_mwe;
      skip_o    <= valid_i & n_skip;
      wb_addr_o <= reg_dest ? AW'({{ROW_W{1'b0}}, lo[COL_W-1:0]}) : {row, col};
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !$past(valid_i) |-> !r_we_o && !m_we_o && !c_we_o && !skip_o);

  // R5
  carry_we_src_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    c_we_o |-> $past(instr_i[IW-1 -: 2] == 2'b01 && instr_i[IW-5]));

  // R10
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(valid_i && instr_i[IW-1 -: 3] == 3'b000) |-> !r_we_o && !m_we_o && !c_we_o);

  // R9
  bit_all_one_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(valid_i && instr_i[IW-1 -: 6] == 6'b111100) |->
      skip_o == (($past(m_i) & $past(instr_i[DW-1:0])) == $past(instr_i[DW-1:0])));

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_we_o && m_we_o));

  // R4
  skip_needs_carry_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(valid_i && instr_i[IW-1 -: 2] == 2'b01) && skip_o |-> c_o && $past(instr_i[IW-6]));
endmodule

// File: tb/test_nibble_alu_skip.sv
module test_nibble_alu_skip;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [3:0]  r_i = '0, m_i = '0;
  logic        c_i = 1'b0;
  logic [3:0]  res_o;
  logic        c_o, c_we_o, r_we_o, m_we_o, skip_o;
  logic [5:0]  wb_addr_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  nibble_alu_skip i_nibble_alu_skip (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
    .r_i(r_i), .m_i(m_i), .c_i(c_i), .res_o(res_o), .c_o(c_o),
    .c_we_o(c_we_o), .r_we_o(r_we_o), .m_we_o(m_we_o), .skip_o(skip_o),
    .wb_addr_o(wb_addr_o)
  );

  // {instr, r, m, c, res, cout, cwe, rwe, mwe, skip, addr, req}
  localparam int NV = 33;
  localparam logic [43:0] VEC [NV] = '{
    {6'b010000,2'd1,4'h3,4'h5, 4'h9,4'h8,1'b1, 4'h1,1'b1,1'b0,1'b1,1'b0,1'b0,6'h05, 4'd2},  // R2 R1
    {6'b010001,2'd1,4'h3,4'h5, 4'h9,4'h8,1'b0, 4'h1,1'b1,1'b0,1'b1,1'b0,1'b1,6'h05, 4'd4},  // R4
    {6'b010001,2'd1,4'h3,4'h5, 4'h3,4'h4,1'b0, 4'h7,1'b0,1'b0,1'b1,1'b0,1'b0,6'h05, 4'd4},  // R4
    {6'b010011,2'd0,4'h0,4'h5, 4'h7,4'h8,1'b1, 4'h0,1'b1,1'b1,1'b1,1'b0,1'b1,6'h05, 4'd5},  // R5
    {6'b010010,2'd0,4'h0,4'h5, 4'h2,4'h3,1'b1, 4'h6,1'b0,1'b1,1'b1,1'b0,1'b0,6'h05, 4'd2},  // R2
    {6'b010101,2'd2,4'hA,4'hF, 4'h0,4'h1,1'b1, 4'h0,1'b1,1'b0,1'b0,1'b1,1'b1,6'h2A, 4'd2},  // R2
    {6'b010111,2'd3,4'hF,4'h0, 4'h0,4'hF,1'b1, 4'h0,1'b1,1'b1,1'b0,1'b1,1'b1,6'h3F, 4'd5},  // R5
    {6'b011000,2'd0,4'h0,4'h2, 4'h5,4'h7,1'b1, 4'hE,1'b1,1'b0,1'b1,1'b0,1'b0,6'h02, 4'd3},  // R3
    {6'b011001,2'd0,4'h0,4'h2, 4'h7,4'h7,1'b0, 4'h0,1'b0,1'b0,1'b1,1'b0,1'b0,6'h02, 4'd3},  // R3
    {6'b011011,2'd0,4'h0,4'h2, 4'h7,4'h7,1'b1, 4'hF,1'b1,1'b1,1'b1,1'b0,1'b1,6'h02, 4'd4},  // R4
    {6'b011101,2'd0,4'h4,4'h3, 4'h0,4'h2,1'b0, 4'hF,1'b1,1'b0,1'b0,1'b1,1'b1,6'h04, 4'd3},  // R3
    {6'b011110,2'd1,4'h0,4'h1, 4'h0,4'h5,1'b1, 4'h3,1'b0,1'b1,1'b0,1'b1,1'b0,6'h10, 4'd3},  // R3
    {6'b000100,2'd0,4'h0,4'h3, 4'h6,4'h6,1'b1, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b1,6'h00, 4'd6},  // R6
    {6'b000100,2'd0,4'h0,4'h3, 4'h6,4'h7,1'b0, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00, 4'd6},  // R6
    {6'b000101,2'd0,4'h0,4'h3, 4'h3,4'h9,1'b0, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00, 4'd6},  // R6
    {6'b000101,2'd0,4'h0,4'h3, 4'h9,4'h9,1'b1, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b1,6'h00, 4'd6},  // R6
    {6'b000110,2'd2,4'h1,4'hA, 4'h0,4'hA,1'b0, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b1,6'h21, 4'd7},  // R7
    {6'b000001,2'd2,4'h1,4'hA, 4'h0,4'hA,1'b0, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,6'h21, 4'd7},  // R7
    {6'b000001,2'd2,4'h1,4'hA, 4'h0,4'hB,1'b0, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b1,6'h21, 4'd7},  // R7
    {6'b000111,2'd0,4'h0,4'h0, 4'h0,4'h0,1'b1, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b1,6'h00, 4'd7},  // R7
    {6'b000011,2'd0,4'h0,4'h5, 4'h0,4'h4,1'b0, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b1,6'h00, 4'd7},  // R7
    {6'b000011,2'd0,4'h0,4'h5, 4'h0,4'h5,1'b0, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,6'h00, 4'd7},  // R7
    {6'b001000,2'd3,4'h3,4'h1, 4'hC,4'hA,1'b1, 4'h8,1'b0,1'b0,1'b1,1'b0,1'b0,6'h01, 4'd8},  // R8
    {6'b001001,2'd2,4'h1,4'h6, 4'h0,4'hC,1'b1, 4'h4,1'b0,1'b0,1'b0,1'b1,1'b0,6'h21, 4'd8},  // R8
    {6'b001010,2'd0,4'h0,4'h7, 4'h5,4'hA,1'b0, 4'hF,1'b0,1'b0,1'b1,1'b0,1'b0,6'h07, 4'd8},  // R8
    {6'b001011,2'd3,4'h2,4'h1, 4'h0,4'h8,1'b0, 4'h9,1'b0,1'b0,1'b0,1'b1,1'b0,6'h32, 4'd8},  // R8
    {6'b001100,2'd2,4'h2,4'h0, 4'hF,4'h5,1'b1, 4'hA,1'b0,1'b0,1'b1,1'b0,1'b0,6'h00, 4'd8},  // R8
    {6'b001110,2'd1,4'h1,4'hF, 4'h0,4'h3,1'b0, 4'hC,1'b0,1'b0,1'b0,1'b1,1'b0,6'h11, 4'd8},  // R8
    {6'b111100,2'd0,4'h5,4'h6, 4'h0,4'h7,1'b0, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b1,6'h05, 4'd9},  // R9
    {6'b111100,2'd0,4'h5,4'h6, 4'h0,4'h5,1'b0, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,6'h05, 4'd9},  // R9
    {6'b111101,2'd0,4'h5,4'h9, 4'h0,4'h6,1'b0, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b1,6'h05, 4'd9},  // R9
    {6'b111101,2'd0,4'h5,4'h9, 4'h0,4'h7,1'b0, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,6'h05, 4'd9},  // R9
    {6'b101000,2'd1,4'h2,4'h3, 4'h4,4'h5,1'b1, 4'h0,1'b0,1'b0,1'b0,1'b0,1'b0,6'h12, 4'd10}  // R10
  };

  function automatic logic [14:0] outs();
    return {res_o, c_o, c_we_o, r_we_o, m_we_o, skip_o, wb_addr_o};
  endfunction

  task automatic check(input logic [14:0] exp, input int req, input string what);
    tests++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, outs(), exp);
    end
  endtask

  task automatic apply(input logic v, input logic [15:0] ins, input logic [3:0] r,
                       input logic [3:0] m, input logic c);
    @(negedge clk);
    valid_i = v; instr_i = ins; r_i = r; m_i = m; c_i = c;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R11: reset clears every output even with a live instruction
    apply(1'b1, {6'b010011, 2'd3, 4'hF, 4'hF}, 4'hF, 4'hF, 1'b1);
    check(15'h0, 11, "reset state");
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      apply(1'b1, VEC[k][43:28], VEC[k][27:24], VEC[k][23:20], VEC[k][19]);
      check(VEC[k][18:4], int'(VEC[k][3:0]), $sformatf("vector %0d", k));
    end

    // R10: an idle cycle after a skipping add raises no enable or skip
    apply(1'b1, {6'b010001, 2'd0, 4'h0, 4'h1}, 4'hF, 4'h1, 1'b0);
    check({4'h0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 6'h01}, 4, "skip before idle");
    apply(1'b0, {6'b010001, 2'd0, 4'h0, 4'h1}, 4'hF, 4'h1, 1'b0);
    check({4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h01}, 10, "idle cycle");

    // R9: an empty mask skips for both bit tests
    apply(1'b1, {6'b111100, 2'd2, 4'h3, 4'h0}, 4'h0, 4'h0, 1'b0);
    check({4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'h23}, 9, "empty mask all-ones");
    apply(1'b1, {6'b111101, 2'd2, 4'h3, 4'h0}, 4'h0, 4'hF, 1'b0);
    check({4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'h23}, 9, "empty mask all-zeros");

    // R11: result appears exactly one edge later, not before
    @(negedge clk);
    valid_i = 1'b1; instr_i = {6'b010100, 2'd1, 4'h1, 4'h2}; m_i = 4'h3; c_i = 1'b0;
    #1;
    check({4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'h23}, 11, "before edge");
    @(posedge clk); #1;
    check({4'h5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'h11}, 11, "after edge");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule